// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources and gives the processor core one request line and the program address of the handler to fetch. Every source is either event-type or level-type, chosen per source by a parameter mask. An event-type source records each occurrence in a pending flag. The flag survives while the source or the whole controller is masked. A level-type source keeps no memory and requests only while its input is high.

A source can win arbitration only when three things hold together: its enable bit is set, the global enable input is high, and the SPI-only restriction does not block it. The lowest source index has the highest priority. Slot zero of the vector table belongs to reset, so source i vectors to `base + 2*(i+1)`. The base is either address 0 or a boot-section address, chosen by a select input. Once the controller raises a request, it holds the vector fixed until the core acknowledges. The acknowledge clears the served event flag, and arbitration then starts again.

Software uses one write port with two targets. One target loads the enable register. The other clears pending flags, where a 1 clears a flag and a 0 leaves it alone.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req` is 0, every pending flag is clear and every enable bit is 0, so turning on the global enable and all enables produces no request.
- R2: No request is raised while `gie` is 0, even with the source enabled and pending.
- R3: An event source (mask bit 0 in `LEVEL_SRC`) whose input is 1 at a clock edge sets its flag even while disabled, and that flag is served once the enables allow it.
- R4: Among eligible sources the lowest index wins, and several pending flags are served one after another in ascending index order.
- R5: When `ack` is 1 at a clock edge while `irq_req` is 1, `irq_req` is 0 after that edge and the served event flag is cleared.
- R6: A write with `wr_sel`=1 clears each flag whose `wr_data` bit is 1; bits written as 0 leave their flags untouched. A write with `wr_sel`=0 loads the enable register from `wr_data`.
- R7: If a source event and a software clear of the same flag meet at one edge, the flag ends up set.
- R8: A level source (mask bit 1 in `LEVEL_SRC`) has no flag: if its input falls before it is enabled, no request follows.
- R9: The vector equals `base + 2*(index+1)`, where base is 0 when `vec_sel` is 0 and `BOOT_BASE` when `vec_sel` is 1.
- R10: While `spi_only` is 1, only source `SPI_IDX` can be requested; other pending flags wait until it returns to 0.
- R11: `irq_req` rises one edge after a source becomes eligible, and `irq_vec` stays unchanged from the rise of `irq_req` until the acknowledge, even if a higher-priority source arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Raw source inputs: event pulses or levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable register, 1 flag clear |
| wr_data | input | N_SRC | Write data |
| gie | input | 1 | Global interrupt enable |
| vec_sel | input | 1 | Vector table base select: 0 low, 1 boot section |
| spi_only | input | 1 | Block every source except the SPI source |
| ack | input | 1 | Core acknowledges the presented vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | ADDR_W | Registered handler address |

## Verification
An event input seen at one edge sets the flag at that edge, and `irq_req` with its vector appears one edge later, so two edges separate the stimulus from the output. A level input, a change to `gie`, or a change to an enable that is already in place shows after one edge. An acknowledge drops the request on the edge that samples it, and the next pending source is presented one edge after that. The bench drives every input at the falling edge and counts rising edges to these exact points before it samples. Checks that something is absent are held over several further cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Words between adjacent vector slots
    localparam int unsigned VEC_STRIDE = 2;
    // Width of the source index carried in the pick struct (up to 256 sources)
    localparam int unsigned IDX_W = 8;

    typedef enum logic {
        WR_ENABLE = 1'b0,
        WR_CLEAR  = 1'b1
    } wr_target_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_HOLD = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Slot 0 of the table is the reset vector; source i lives in slot i+1
    function automatic logic [31:0] slot_addr(logic [31:0] base, logic [IDX_W-1:0] idx);
        return base + (32'(idx) + 32'd1) * VEC_STRIDE;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int unsigned       N_SRC     = 16,
    parameter logic [N_SRC-1:0]  LEVEL_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic [N_SRC-1:0] hw_clr,
    output logic [N_SRC-1:0] pend
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (LEVEL_SRC[i]) begin : g_level
            // Level-type: no storage, request follows the input
            assign pend[i] = src_in[i];
        end else begin : g_event
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)
                    flag_q <= 1'b0;
                else if (src_in[i])
                    flag_q <= 1'b1;           // set has priority over any clear
                else if (sw_clr[i] || hw_clr[i])
                    flag_q <= 1'b0;
            end
            assign pend[i] = flag_q;

            p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
                src_in[i] |=> pend[i]);
            p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
                (hw_clr[i] && !src_in[i]) |=> !pend[i]);
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
#(
    parameter int unsigned N_SRC = 16
) (
    input  logic [N_SRC-1:0] elig,
    output pick_t            pick
);

    always_comb begin
        pick = '0;
        // Walk from the top down so the lowest index is the last to write
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned       N_SRC     = 16,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [31:0]       BOOT_BASE = 32'h0000_3800,
    parameter int unsigned       SPI_IDX   = 9,
    parameter logic [N_SRC-1:0]  LEVEL_SRC = 16'h00C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [N_SRC-1:0]  wr_data,
    input  logic              gie,
    input  logic              vec_sel,
    input  logic              spi_only,
    input  logic              ack,
    output logic              irq_req,
    output logic [ADDR_W-1:0] irq_vec
);

    localparam logic [N_SRC-1:0] SPI_BIT = N_SRC'(1) << SPI_IDX;

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] sw_clr;
    logic [N_SRC-1:0] hw_clr;
    logic [N_SRC-1:0] elig;
    pick_t            pick;
    ctl_state_e       state_q;
    logic [IDX_W-1:0] held_idx_q;
    logic [31:0]      base;
    logic             take_ack;

    // Software write port
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en && wr_target_e'(wr_sel) == WR_ENABLE)
            en_q <= wr_data;
    end

    assign sw_clr   = (wr_en && wr_target_e'(wr_sel) == WR_CLEAR) ? wr_data : '0;
    assign take_ack = (state_q == CTL_HOLD) && ack;
    assign hw_clr   = take_ack ? (N_SRC'(1) << held_idx_q) : '0;

    irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_SRC(LEVEL_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .sw_clr (sw_clr),
        .hw_clr (hw_clr),
        .pend   (pend)
    );

    assign elig = pend & en_q & {N_SRC{gie}} & (spi_only ? SPI_BIT : '1);

    irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .elig (elig),
        .pick (pick)
    );

    assign base = vec_sel ? BOOT_BASE : 32'd0;

    // Request/vector register: latch a winner, hold it until acknowledged
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CTL_IDLE;
            held_idx_q <= '0;
            irq_vec    <= '0;
        end else begin
            case (state_q)
                CTL_IDLE: if (pick.valid) begin
                    state_q    <= CTL_HOLD;
                    held_idx_q <= pick.idx;
                    irq_vec    <= ADDR_W'(slot_addr(base, pick.idx));
                end
                CTL_HOLD: if (ack) state_q <= CTL_IDLE;
                default:  state_q <= CTL_IDLE;
            endcase
        end
    end

    assign irq_req = (state_q == CTL_HOLD);

    p_one_hw_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hw_clr));
    p_ack_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_req && ack) |=> !irq_req);
    p_vec_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !ack) |=> (irq_req && $stable(irq_vec)));
    p_gie_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(gie));
    p_spi_only_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_req) && $past(spi_only)) |->
            irq_vec == ADDR_W'(($past(vec_sel) ? BOOT_BASE : 32'd0) + (SPI_IDX + 1) * VEC_STRIDE));

endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;

    localparam int N = 16;
    localparam int AW = 16;
    localparam int BOOT = 'h3800;
    localparam int SPI = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_in = '0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [N-1:0]  wr_data = '0;
    logic          gie = 1'b0;
    logic          vec_sel = 1'b0;
    logic          spi_only = 1'b0;
    logic          ack = 1'b0;
    logic          irq_req;
    logic [AW-1:0] irq_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    irq_vec_ctrl u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .gie(gie), .vec_sel(vec_sel), .spi_only(spi_only),
        .ack(ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] vaddr(int base, int idx);
        return 32'(base + 2 * (idx + 1));
    endfunction

    task automatic write_reg(logic sel, logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(logic [N-1:0] bits);
        src_in = bits;
        step(1);
        src_in = '0;
    endtask

    // Acknowledge the held vector and check the request falls
    task automatic do_ack(string req);
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        check(req, 32'(irq_req), 0);
    endtask

    task automatic t_reset;
        check("R1 req after reset", 32'(irq_req), 0);
        write_reg(1'b0, '1);
        gie = 1'b1;
        step(4);
        check("R1 no flags after reset", 32'(irq_req), 0);
        gie = 1'b0;
    endtask

    task automatic t_gate;
        pulse(N'(1) << 3);
        step(3);
        check("R2 gie low blocks", 32'(irq_req), 0);
        gie = 1'b1;
        step(1);
        check("R3 latched flag served", 32'(irq_req), 1);
        check("R3 vector of source 3", 32'(irq_vec), vaddr(0, 3));
        do_ack("R5 req drops on ack");
        step(3);
        check("R5 flag cleared by ack", 32'(irq_req), 0);
        gie = 1'b0;
    endtask

    task automatic t_priority;
        pulse((N'(1) << 5) | (N'(1) << 2) | (N'(1) << 12));
        gie = 1'b1;
        step(1);
        check("R4 first pick", 32'(irq_vec), vaddr(0, 2));
        do_ack("R5 drop after first");
        step(1);
        check("R4 second pick", 32'(irq_vec), vaddr(0, 5));
        do_ack("R5 drop after second");
        step(1);
        check("R4 third pick", 32'(irq_vec), vaddr(0, 12));
        do_ack("R5 drop after third");
        step(3);
        check("R4 queue empty", 32'(irq_req), 0);
        gie = 1'b0;
    endtask

    task automatic t_clear;
        pulse((N'(1) << 4) | (N'(1) << 8));
        write_reg(1'b1, N'(1) << 4);
        write_reg(1'b1, '0);
        gie = 1'b1;
        step(1);
        check("R6 cleared flag skipped", 32'(irq_req), 1);
        check("R6 zero write keeps flag", 32'(irq_vec), vaddr(0, 8));
        do_ack("R5 drop");
        step(3);
        check("R6 nothing left", 32'(irq_req), 0);
        gie = 1'b0;
        // Event and clear on the same edge
        src_in = N'(1) << 1;
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = N'(1) << 1;
        step(1);
        src_in = '0; wr_en = 1'b0; wr_data = '0;
        gie = 1'b1;
        step(1);
        check("R7 set beats clear", 32'(irq_vec), vaddr(0, 1));
        check("R7 request present", 32'(irq_req), 1);
        do_ack("R5 drop");
        gie = 1'b0;
    endtask

    task automatic t_level;
        write_reg(1'b0, ~(N'(1) << 6));
        gie = 1'b1;
        src_in = N'(1) << 6;
        step(3);
        src_in = '0;
        write_reg(1'b0, '1);
        step(3);
        check("R8 vanished level ignored", 32'(irq_req), 0);
        src_in = N'(1) << 6;
        step(1);
        check("R8 level requests", 32'(irq_req), 1);
        check("R8 level vector", 32'(irq_vec), vaddr(0, 6));
        src_in = '0;
        do_ack("R5 drop");
        step(3);
        check("R8 no memory of level", 32'(irq_req), 0);
        gie = 1'b0;
    endtask

    task automatic t_vecsel;
        vec_sel = 1'b1;
        pulse(N'(1) << 0);
        gie = 1'b1;
        step(1);
        check("R9 boot base vector", 32'(irq_vec), vaddr(BOOT, 0));
        do_ack("R5 drop");
        vec_sel = 1'b0;
        gie = 1'b0;
    endtask

    task automatic t_spi;
        spi_only = 1'b1;
        pulse((N'(1) << 0) | (N'(1) << SPI));
        gie = 1'b1;
        step(1);
        check("R10 spi passes", 32'(irq_vec), vaddr(0, SPI));
        do_ack("R5 drop");
        step(3);
        check("R10 others blocked", 32'(irq_req), 0);
        spi_only = 1'b0;
        step(1);
        check("R10 blocked source released", 32'(irq_vec), vaddr(0, 0));
        do_ack("R5 drop");
        gie = 1'b0;
    endtask

    task automatic t_stable;
        gie = 1'b1;
        pulse(N'(1) << 10);
        step(1);
        check("R11 request rises", 32'(irq_req), 1);
        pulse(N'(1) << 0);
        step(2);
        check("R11 vector held", 32'(irq_vec), vaddr(0, 10));
        check("R11 request held", 32'(irq_req), 1);
        do_ack("R5 drop");
        step(1);
        check("R11 next after ack", 32'(irq_vec), vaddr(0, 0));
        do_ack("R5 drop");
        gie = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_gate();
        t_priority();
        t_clear();
        t_level();
        t_vecsel();
        t_spi();
        t_stable();
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule